// File: doc/BRIEF.md
# SDRAM Mode Register Loader

This block is the configuration front end of an SDR SDRAM controller. A host writes byte-wide registers that hold the burst length, the burst ordering (wrap type) and the CAS latency. It also writes a one-bit trigger register. When the trigger bit changes from 0 to 1, the block takes a snapshot of the settings. It then drives a precharge-all command, waits a parameterised number of cycles, and drives a load-mode-register command with the mode word on the address lines. After a second parameterised wait it raises a one-cycle done pulse. A busy output covers the whole sequence.

The CAS latency field accepts any 3-bit value. Only 2 and 3 ever reach the SDRAM: lower values become 2, higher values become 3, and an error output shows that the stored value is illegal. A trigger edge that arrives during a running sequence is held and runs once the current sequence ends. The block also keeps a sticky BIST failure flag. It captures this flag from an external test engine whenever that engine reports completion.

Top module: `sdram_mode_loader`

## Requirements
- R1: After reset the register at 0x3A reads 0x03, 0x3B reads 0x02 and 0x3C reads 0x00. The command pins show NOP (RAS#, CAS#, WE# all high, address 0), busy and done are low, and the BIST fail flag and CAS error are low.
- R2: Register 0x3A keeps wrap type in bit 3 and burst length in bits 2:0. Register 0x3B keeps CAS latency in bits 2:0. Register 0x3C keeps the trigger in bit 0. Unused bits read 0 whatever was written, and any other read address returns 0x00.
- R3: A 0-to-1 write of the trigger bit produces a precharge-all command (RAS# low, CAS# high, WE# low, only address bit 10 set). Exactly PRECHARGE_WAIT NOP cycles follow, then one load-mode command (RAS#, CAS#, WE# all low).
- R4: During the load-mode command the address carries burst length on A2:A0, wrap type on A3 (0 sequential, 1 interleaved) and CAS latency on A6:A4. All higher address bits are 0.
- R5: A stored CAS latency of 0 or 1 is sent as 2, and 4 to 7 is sent as 3. The CAS error output is high exactly while the stored value is outside {2, 3}.
- R6: Writing 1 to a trigger bit that already holds 1 starts no sequence. Writing 0 starts none either.
- R7: Configuration writes without a trigger edge issue no command. A sequence uses the settings that were stored when it started, even if they change while it runs.
- R8: Exactly LOAD_WAIT NOP cycles after the load-mode command, done is high for one cycle. Busy is high in that cycle and drops in the next one unless another sequence is pending.
- R9: A trigger edge made while a sequence runs is not lost. A second full sequence follows the first one's done pulse.
- R10: The BIST fail flag is set when the fail input is high in a cycle where the done input is high. It ignores the fail input while done is low, and once set it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostWrAddr | input | 8 | Host write address |
| hostWrData | input | 8 | Host write data |
| hostRdAddr | input | 8 | Host read address |
| hostRdData | output | 8 | Host read data (combinational) |
| bistDone | input | 1 | External BIST completion indication |
| bistFail | input | 1 | External BIST failure result |
| bistFailFlag | output | 1 | Sticky BIST failure flag |
| casErr | output | 1 | Stored CAS latency is illegal |
| sdCsN | output | 1 | SDRAM chip select, held active |
| sdRasN | output | 1 | SDRAM row strobe |
| sdCasN | output | 1 | SDRAM column strobe |
| sdWeN | output | 1 | SDRAM write enable |
| sdAddr | output | ADDR_W | SDRAM address lines |
| seqBusy | output | 1 | Command sequence in progress or pending |
| seqDone | output | 1 | One-cycle pulse at end of sequence |

## Verification
Random burst length, wrap type and full-range CAS values are sent through complete sequences, one at a time. Because the CAS values cover every code, the clamping of both illegal ranges is compared against the passed-through legal codes. Directed cases cover a repeated 1 write and a 0 write to the trigger, which must stay silent, as opposed to a true 0-to-1 edge. They also cover configuration edits without a trigger. A pending retrigger with changed settings during a live sequence shows whether the running sequence holds its snapshot and whether the queued edge survives. BIST inputs are exercised with fail asserted both with and without the done qualifier, so that capture is told apart from stickiness.

// File: rtl/sdml_pkg.sv
package sdml_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_WAIT_RP,
    ST_LOAD,
    ST_WAIT_MRD,
    ST_FINISH
  } seq_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchMode;
    logic issuePre;
    logic issueLoad;
    logic finish;
    logic busy;
  } seq_strobe_t;

  // {RAS#, CAS#, WE#}
  typedef logic [2:0] sd_cmd_t;
  localparam sd_cmd_t CMD_NOP  = 3'b111;
  localparam sd_cmd_t CMD_PRE  = 3'b010;
  localparam sd_cmd_t CMD_LOAD = 3'b000;

  localparam int PRE_ALL_BIT = 10;
  localparam int MODE_BITS   = 7;

endpackage

// File: rtl/sdml_regs.sv
module sdml_regs #(
  parameter logic [7:0] REG_BURST = 8'h3A,
  parameter logic [7:0] REG_CAS   = 8'h3B,
  parameter logic [7:0] REG_TRIG  = 8'h3C
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [7:0] rdAddr,
  output logic [7:0] rdData,
  input  logic       bistDone,
  input  logic       bistFail,
  output logic       bistFailFlag,
  output logic [2:0] burstLen,
  output logic       wrapType,
  output logic [2:0] casLat,
  output logic       casErr,
  output logic       trigEdge
);

  logic [2:0] casRaw;
  logic       trigBit;
  logic       unusedBits;

  assign unusedBits = ^wrData[7:4];

  // a trigger edge is a write of 1 while the stored bit is 0
  assign trigEdge = wrEn && (wrAddr == REG_TRIG) && wrData[0] && !trigBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstLen     <= 3'd3;
      wrapType     <= 1'b0;
      casRaw       <= 3'd2;
      trigBit      <= 1'b0;
      bistFailFlag <= 1'b0;
    end else begin
      if (wrEn) begin
        if (wrAddr == REG_BURST) begin
          burstLen <= wrData[2:0];
          wrapType <= wrData[3];
        end
        if (wrAddr == REG_CAS)  casRaw  <= wrData[2:0];
        if (wrAddr == REG_TRIG) trigBit <= wrData[0];
      end
      if (bistDone && bistFail) bistFailFlag <= 1'b1;
    end
  end

  always_comb begin
    casErr = (casRaw < 3'd2) || (casRaw > 3'd3);
    if (casRaw < 3'd2)      casLat = 3'd2;
    else if (casRaw > 3'd3) casLat = 3'd3;
    else                    casLat = casRaw;
  end

  always_comb begin
    rdData = 8'h00;
    if (rdAddr == REG_BURST)     rdData = {4'b0, wrapType, burstLen};
    else if (rdAddr == REG_CAS)  rdData = {5'b0, casRaw};
    else if (rdAddr == REG_TRIG) rdData = {7'b0, trigBit};
  end

endmodule

// File: rtl/sdml_ctrl.sv
module sdml_ctrl
  import sdml_pkg::*;
#(
  parameter int PRECHARGE_WAIT = 3,
  parameter int LOAD_WAIT      = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigEdge,
  output seq_strobe_t strobe
);

  localparam int MAX_WAIT = (PRECHARGE_WAIT > LOAD_WAIT) ? PRECHARGE_WAIT : LOAD_WAIT;
  localparam int CNT_W    = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT);

  seq_state_t       state;
  logic             pending;
  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      waitCnt <= '0;
    end else begin
      pending <= trigEdge || (pending && (state != ST_IDLE));
      case (state)
        ST_IDLE:     if (pending) state <= ST_PRE;
        ST_PRE: begin
          state   <= ST_WAIT_RP;
          waitCnt <= CNT_W'(PRECHARGE_WAIT - 1);
        end
        ST_WAIT_RP:  if (waitCnt == '0) state <= ST_LOAD;
                     else waitCnt <= waitCnt - 1'b1;
        ST_LOAD: begin
          state   <= ST_WAIT_MRD;
          waitCnt <= CNT_W'(LOAD_WAIT - 1);
        end
        ST_WAIT_MRD: if (waitCnt == '0) state <= ST_FINISH;
                     else waitCnt <= waitCnt - 1'b1;
        ST_FINISH:   state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.latchMode = (state == ST_IDLE) && pending;
    strobe.issuePre  = (state == ST_PRE);
    strobe.issueLoad = (state == ST_LOAD);
    strobe.finish    = (state == ST_FINISH);
    strobe.busy      = (state != ST_IDLE) || pending;
  end

endmodule

// File: rtl/sdml_dp.sv
module sdml_dp
  import sdml_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [2:0]        burstLen,
  input  logic              wrapType,
  input  logic [2:0]        casLat,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              seqDone,
  output logic              seqBusy
);

  logic [MODE_BITS-1:0] modeSnap;
  sd_cmd_t              cmdNext;
  logic [ADDR_W-1:0]    addrNext;

  always_comb begin
    cmdNext  = CMD_NOP;
    addrNext = '0;
    if (strobe.issuePre) begin
      cmdNext               = CMD_PRE;
      addrNext[PRE_ALL_BIT] = 1'b1;
    end else if (strobe.issueLoad) begin
      cmdNext                   = CMD_LOAD;
      addrNext[MODE_BITS-1:0]   = modeSnap;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSnap               <= '0;
      {sdRasN, sdCasN, sdWeN} <= CMD_NOP;
      sdAddr                 <= '0;
      seqDone                <= 1'b0;
      seqBusy                <= 1'b0;
    end else begin
      if (strobe.latchMode) modeSnap <= {casLat, wrapType, burstLen};
      {sdRasN, sdCasN, sdWeN} <= cmdNext;
      sdAddr                 <= addrNext;
      seqDone                <= strobe.finish;
      seqBusy                <= strobe.busy;
    end
  end

endmodule

// File: rtl/sdram_mode_loader.sv
module sdram_mode_loader
  import sdml_pkg::*;
#(
  parameter int         ADDR_W         = 13,
  parameter int         PRECHARGE_WAIT = 3,
  parameter int         LOAD_WAIT      = 2,
  parameter logic [7:0] REG_BURST      = 8'h3A,
  parameter logic [7:0] REG_CAS        = 8'h3B,
  parameter logic [7:0] REG_TRIG       = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [7:0]        hostWrAddr,
  input  logic [7:0]        hostWrData,
  input  logic [7:0]        hostRdAddr,
  output logic [7:0]        hostRdData,
  input  logic              bistDone,
  input  logic              bistFail,
  output logic              bistFailFlag,
  output logic              casErr,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              seqBusy,
  output logic              seqDone
);

  logic [2:0]  burstLen;
  logic        wrapType;
  logic [2:0]  casLat;
  logic        trigEdge;
  seq_strobe_t strobe;

  assign sdCsN = 1'b0;

  sdml_regs #(.REG_BURST(REG_BURST), .REG_CAS(REG_CAS), .REG_TRIG(REG_TRIG)) u_regs (
    .clk(clk), .rstN(rstN),
    .wrEn(hostWrEn), .wrAddr(hostWrAddr), .wrData(hostWrData),
    .rdAddr(hostRdAddr), .rdData(hostRdData),
    .bistDone(bistDone), .bistFail(bistFail), .bistFailFlag(bistFailFlag),
    .burstLen(burstLen), .wrapType(wrapType), .casLat(casLat), .casErr(casErr),
    .trigEdge(trigEdge)
  );

  sdml_ctrl #(.PRECHARGE_WAIT(PRECHARGE_WAIT), .LOAD_WAIT(LOAD_WAIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigEdge(trigEdge), .strobe(strobe)
  );

  sdml_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .burstLen(burstLen), .wrapType(wrapType), .casLat(casLat),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdAddr(sdAddr),
    .seqDone(seqDone), .seqBusy(seqBusy)
  );

endmodule

// File: rtl/sdml_checker.sv
module sdml_checker #(
  parameter int ADDR_W         = 13,
  parameter int PRECHARGE_WAIT = 3,
  parameter int LOAD_WAIT      = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdRasN,
  input logic              sdCasN,
  input logic              sdWeN,
  input logic [ADDR_W-1:0] sdAddr,
  input logic              seqDone,
  input logic              seqBusy,
  input logic              bistFailFlag
);

  logic        isPre, isLoad, isNop;
  logic [15:0] nopSincePre;
  logic [15:0] nopSinceLoad;

  assign isPre  = !sdRasN &&  sdCasN && !sdWeN;
  assign isLoad = !sdRasN && !sdCasN && !sdWeN;
  assign isNop  =  sdRasN &&  sdCasN &&  sdWeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nopSincePre  <= '0;
      nopSinceLoad <= '0;
    end else begin
      if (isPre) nopSincePre <= '0;
      else if (isNop && nopSincePre != 16'hFFFF) nopSincePre <= nopSincePre + 1'b1;
      if (isLoad) nopSinceLoad <= '0;
      else if (isNop && nopSinceLoad != 16'hFFFF) nopSinceLoad <= nopSinceLoad + 1'b1;
    end
  end

  AST_PRE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> (sdAddr == ADDR_W'(1 << 10)));  // R3
  AST_LOAD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    isLoad |-> (nopSincePre == 16'(PRECHARGE_WAIT)));  // R3
  AST_LOAD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    isLoad |-> (sdAddr[ADDR_W-1:7] == '0));  // R4
  AST_LOAD_CAS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    isLoad |-> (sdAddr[6:4] == 3'd2 || sdAddr[6:4] == 3'd3));  // R5
  AST_DONE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (nopSinceLoad == 16'(LOAD_WAIT)));  // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);  // R8
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> seqBusy);  // R8
  AST_BIST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    bistFailFlag |=> bistFailFlag);  // R10

endmodule

bind sdram_mode_loader sdml_checker #(
  .ADDR_W(ADDR_W), .PRECHARGE_WAIT(PRECHARGE_WAIT), .LOAD_WAIT(LOAD_WAIT)
) u_chk (
  .clk(clk), .rstN(rstN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
  .sdAddr(sdAddr), .seqDone(seqDone), .seqBusy(seqBusy), .bistFailFlag(bistFailFlag)
);

// File: tb/sdram_mode_loader_bench.sv
`timescale 1ns/1ps
module sdram_mode_loader_bench;

  localparam int ADDR_W = 13;
  localparam int PRE_W  = 3;
  localparam int LOAD_W = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              hostWrEn = 1'b0;
  logic [7:0]        hostWrAddr = '0;
  logic [7:0]        hostWrData = '0;
  logic [7:0]        hostRdAddr = '0;
  logic [7:0]        hostRdData;
  logic              bistDone = 1'b0;
  logic              bistFail = 1'b0;
  logic              bistFailFlag, casErr, sdCsN, sdRasN, sdCasN, sdWeN, seqBusy, seqDone;
  logic [ADDR_W-1:0] sdAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  sdram_mode_loader #(.ADDR_W(ADDR_W), .PRECHARGE_WAIT(PRE_W), .LOAD_WAIT(LOAD_W)) u_sdram_mode_loader (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrAddr(hostWrAddr),
    .hostWrData(hostWrData), .hostRdAddr(hostRdAddr), .hostRdData(hostRdData),
    .bistDone(bistDone), .bistFail(bistFail), .bistFailFlag(bistFailFlag),
    .casErr(casErr), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdAddr(sdAddr), .seqBusy(seqBusy), .seqDone(seqDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] cmdNow();
    return {sdRasN, sdCasN, sdWeN};
  endfunction

  function automatic logic [6:0] expMode(input logic [2:0] bl, input logic wt, input logic [2:0] cl);
    logic [2:0] c;
    c = (cl < 3'd2) ? 3'd2 : ((cl > 3'd3) ? 3'd3 : cl);
    return {c, wt, bl};
  endfunction

  task automatic hostWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    hostRdAddr = a;
    #1 d = hostRdData;
  endtask

  task automatic quietFor(input int n, input string req);
    bit clean = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cmdNow() != 3'b111 || seqDone || sdAddr != '0) clean = 0;
    end
    check(clean, req, "no command expected", int'(cmdNow()), 7);
  endtask

  task automatic runSeq(input logic [6:0] mode, input bit expectIdle, input string ctx,
                        output bit seen);
    int gap;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cmdNow() == 3'b010) begin seen = 1; break; end
    end
    check(seen, "R3", {ctx, " precharge seen"}, int'(seen), 1);
    if (!seen) return;
    check(sdAddr == 13'h400, "R3", {ctx, " precharge address"}, int'(sdAddr), 'h400);
    gap = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cmdNow() != 3'b111) break;
      gap++;
    end
    check(cmdNow() == 3'b000, "R3", {ctx, " load command"}, int'(cmdNow()), 0);
    check(gap == PRE_W, "R3", {ctx, " precharge gap"}, gap, PRE_W);
    check(sdAddr == {6'b0, mode}, "R4", {ctx, " mode word"}, int'(sdAddr), int'(mode));
    gap = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (seqDone) break;
      gap++;
    end
    check(gap == LOAD_W, "R8", {ctx, " done gap"}, gap, LOAD_W);
    check(seqBusy, "R8", {ctx, " busy at done"}, int'(seqBusy), 1);
    if (expectIdle) begin
      @(negedge clk);
      check(!seqBusy && !seqDone, "R8", {ctx, " idle after done"},
            int'({seqBusy, seqDone}), 0);
    end
  endtask

  initial begin
    #800000;
    nFails++;
    $display("FAIL watchdog expired, run hung");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [6:0] modeA, modeB;
    bit s1, s2;
    void'($urandom(32'h5EED1234));

    repeat (4) @(negedge clk);
    // R1 reset state
    check(cmdNow() == 3'b111 && sdAddr == '0, "R1", "cmd at reset", int'(cmdNow()), 7);
    check(!seqBusy && !seqDone, "R1", "busy/done at reset", int'({seqBusy, seqDone}), 0);
    check(!bistFailFlag && !casErr, "R1", "flags at reset", int'({bistFailFlag, casErr}), 0);
    rstN = 1'b1;
    hostRead(8'h3A, rd); check(rd == 8'h03, "R1", "burst reg default", rd, 'h03);
    hostRead(8'h3B, rd); check(rd == 8'h02, "R1", "cas reg default", rd, 'h02);
    hostRead(8'h3C, rd); check(rd == 8'h00, "R1", "trigger default", rd, 'h00);

    // R2 fields and reserved bits
    hostWrite(8'h3A, 8'hFF); hostRead(8'h3A, rd); check(rd == 8'h0F, "R2", "burst reg mask", rd, 'h0F);
    hostWrite(8'h3B, 8'hFF); hostRead(8'h3B, rd); check(rd == 8'h07, "R2", "cas reg mask", rd, 'h07);
    check(casErr, "R5", "cas 7 flagged", int'(casErr), 1);
    hostWrite(8'h3C, 8'hFE); hostRead(8'h3C, rd); check(rd == 8'h00, "R2", "trigger mask", rd, 0);
    hostRead(8'h55, rd); check(rd == 8'h00, "R2", "unmapped read", rd, 0);
    quietFor(8, "R6");

    // first trigger: bl 7, interleave, cas 7 -> 3
    hostWrite(8'h3C, 8'hFF);
    runSeq(expMode(3'd7, 1'b1, 3'd7), 1'b1, "first", s1);
    hostRead(8'h3C, rd); check(rd == 8'h01, "R2", "trigger reads 1", rd, 1);

    // R6 rewrite 1 starts nothing
    hostWrite(8'h3C, 8'h01);
    quietFor(12, "R6");
    // R7 config change only
    hostWrite(8'h3A, 8'h02);
    hostWrite(8'h3B, 8'h00);
    check(casErr, "R5", "cas 0 flagged", int'(casErr), 1);
    quietFor(12, "R7");
    // R6 writing 0 is silent, then 0->1 runs
    hostWrite(8'h3C, 8'h00);
    quietFor(6, "R6");
    hostWrite(8'h3C, 8'h01);
    runSeq(expMode(3'd2, 1'b0, 3'd0), 1'b1, "R5 low clamp", s1);

    // R9 / R7 retrigger while busy with new settings
    hostWrite(8'h3B, 8'h03);
    hostWrite(8'h3A, 8'h01);
    modeA = expMode(3'd1, 1'b0, 3'd3);
    modeB = expMode(3'd5, 1'b1, 3'd2);
    hostWrite(8'h3C, 8'h00);
    fork
      begin
        runSeq(modeA, 1'b0, "R7 snapshot", s1);
        runSeq(modeB, 1'b1, "R9 queued", s2);
      end
      begin
        hostWrite(8'h3C, 8'h01);
        hostWrite(8'h3A, 8'h0D);
        hostWrite(8'h3B, 8'h02);
        hostWrite(8'h3C, 8'h00);
        hostWrite(8'h3C, 8'h01);
      end
    join
    check(s1 && s2, "R9", "two sequences", int'({s1, s2}), 3);
    check(!casErr, "R5", "cas 2 legal", int'(casErr), 0);

    // random sweep
    for (int it = 0; it < 24; it++) begin
      logic [2:0] bl, cl;
      logic wt;
      bl = 3'($urandom); cl = 3'($urandom); wt = 1'($urandom);
      hostWrite(8'h3A, {4'($urandom), wt, bl});
      hostWrite(8'h3B, {5'($urandom), cl});
      check(casErr == (cl < 3'd2 || cl > 3'd3), "R5", "cas error flag",
            int'(casErr), int'(cl < 3'd2 || cl > 3'd3));
      hostWrite(8'h3C, 8'h00);
      hostWrite(8'h3C, 8'h01);
      runSeq(expMode(bl, wt, cl), 1'b1, "R4 random", s1);
    end

    // R10 BIST flag
    @(negedge clk); bistFail = 1'b1; bistDone = 1'b0;
    @(negedge clk); check(!bistFailFlag, "R10", "fail without done ignored", int'(bistFailFlag), 0);
    bistFail = 1'b0; bistDone = 1'b1;
    @(negedge clk); check(!bistFailFlag, "R10", "pass result", int'(bistFailFlag), 0);
    bistFail = 1'b1;
    @(negedge clk); check(bistFailFlag, "R10", "fail captured", int'(bistFailFlag), 1);
    bistFail = 1'b0;
    repeat (3) @(negedge clk);
    check(bistFailFlag, "R10", "flag sticky", int'(bistFailFlag), 1);
    bistDone = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule